// File: doc/BRIEF.md
# NAND BCH parity generator

This block computes binary BCH parity over NAND page data while the data streams past the memory controller. A page is handled as a run of one to eight 512-byte sectors. Each sector's data is divided by a BCH generator polynomial over GF(2^13), and the remainder is stored in that sector's own result bank. A correction strength of 4 bits (52 parity bits) or 8 bits (104 parity bits) is chosen when the run starts. Spare-area bytes that sit between sectors are counted and skipped, so they never reach the remainder.

Software programs a configuration word and then writes a control word that clears the banks and starts a run. The block then consumes one byte (x8) or one halfword (x16) per valid beat. A done flag rises on the beat that completes the last programmed sector, and data after that point is ignored.

Alongside the raw banks, the block produces a byte-packed parity view for every sector. In this view the remainder is left-justified and XORed with a constant mask. The mask is chosen so that an erased sector of all-0xFF bytes yields all-0xFF parity.

Top module: `nand_bch_parity`

## Requirements
- R1: Each sector is exactly 512 data bytes. Its stored remainder equals D(x)·x^N mod g(x), where D(x) is the sector's bit stream taken in arrival order with each byte's bit 7 first. In x8 mode a beat carries `data_i[7:0]`, and `data_i[15:8]` is ignored.
- R2: GF(2^13) uses the primitive polynomial x^13+x^4+x^3+x+1. With configuration bit 12 = 0 (4-bit strength), N = 52 and g(x) is the product of the minimal polynomials of α, α^3, α^5 and α^7. With bit 12 = 1 (8-bit strength), N = 104 and g(x) is the product of the minimal polynomials of α^1 through α^15 (odd powers).
- R3: With configuration bit 7 = 1 (x16), each beat carries two data bytes, fed `data_i[15]` first down to `data_i[0]`. A sector is then 256 beats.
- R4: Configuration bits 6:4 hold the sector count minus one. Sector s's remainder appears in `bank_o[s*128 +: 128]` as four 32-bit words, with remainder bit 0 at bank bit 0. Bank bits above N are zero.
- R5: When configuration bits 11:8 equal 6, 16 spare bytes after each non-last sector are skipped (16 beats in x8, 8 in x16). With any other value, sectors follow back to back.
- R6: `done_o` rises on the clock edge that accepts the last data beat of the last sector and stays high until the next clear. While it is high, data beats change no bank.
- R7: A control write with `ctl_i[0]` = 1 clears every bank and drops `done_o`. A run starts only if `ctl_i[8]` is also 1 and configuration bits 0 and 16 are both 1. Otherwise the block stays idle and ignores data.
- R8: `parity_o[s*104 +: 104]` holds sector s's packed parity with byte 0 in the top byte. At 8-bit strength it is the remainder XOR a mask. At 4-bit strength it is {remainder, 4'b0} in the top 56 bits XOR a mask, and the low 48 bits are zero. For an all-0xFF sector, every used parity bit is 1.
- R9: After reset every bank is zero and `done_o` is low.
- R10: The configuration word is sampled only when a run starts. Later changes to `cfg_i` do not affect that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | 32 | Configuration word |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_i | input | 16 | Control word (bit 0 clear, bit 8 start) |
| data_i | input | 16 | Stream data, byte in bits 7:0 for x8 |
| data_vld_i | input | 1 | Data beat valid |
| bank_o | output | N_SECTORS*128 | Raw remainder banks |
| parity_o | output | N_SECTORS*104 | Masked, byte-packed parity per sector |
| done_o | output | 1 | Run complete |

## Verification
The bench targets several corner cases.
- Erased sectors: a design with a wrong mask or wrong justification would not return all-ones parity.
- All-zero sectors: these expose a remainder that leaks state from the previous sector or run.
- Hashed data: checked at both strengths and both widths against a bit-serial long division, where a wrong generator, bit order or halfword byte order shows up in every bank.
- Spare-skip and no-skip runs, swept from one to eight sectors: an off-by-one in the sector or spare counters would shift later sectors' data and corrupt their banks.
- Control and configuration: clear-only writes, a start with BCH disabled, data after done and a configuration change mid-run each have to leave the banks exactly as expected.

// File: rtl/nbp_pkg.sv
package nbp_pkg;

    localparam int GF_M         = 13;
    localparam int GF_N         = (1 << GF_M) - 1;
    localparam logic [GF_M:0] GF_PRIM = 14'h201B;
    localparam int PAR_MAX      = 104;
    localparam int BANK_W       = 128;
    localparam int SECTOR_BYTES = 512;
    localparam int SPARE_SKIP   = 16;
    localparam int MAX_SECTORS  = 8;
    localparam int SEC_W        = 3;
    localparam int CNT_W        = $clog2(SECTOR_BYTES) + 1;
    localparam logic [3:0] WRAP_SKIP = 4'd6;

    typedef struct packed {
        logic       bch_en;
        logic       t8;
        logic [3:0] wrap;
        logic       wide;
        logic [2:0] nsec_m1;
        logic [2:0] chip;
        logic       ecc_en;
    } cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_DATA,
        PH_SPARE,
        PH_DONE
    } phase_e;

    function automatic cfg_t cfg_decode(input logic [31:0] w);
        cfg_t c;
        c.ecc_en  = w[0];
        c.chip    = w[3:1];
        c.nsec_m1 = w[6:4];
        c.wide    = w[7];
        c.wrap    = w[11:8];
        c.t8      = w[12];
        c.bch_en  = w[16];
        return c;
    endfunction

    // GF(2^13) product by shift-and-reduce
    function automatic logic [GF_M-1:0] gf_mul(input logic [GF_M-1:0] a,
                                              input logic [GF_M-1:0] b);
        logic [GF_M-1:0] acc;
        logic [GF_M:0]   sh;
        acc = '0;
        sh  = {1'b0, a};
        for (int i = 0; i < GF_M; i++) begin
            if (b[i]) acc = acc ^ sh[GF_M-1:0];
            sh = sh << 1;
            if (sh[GF_M]) sh = sh ^ GF_PRIM;
        end
        return acc;
    endfunction

    function automatic logic [GF_M-1:0] gf_pow(input int e);
        logic [GF_M-1:0] res;
        logic [GF_M-1:0] base;
        int              k;
        res  = 13'd1;
        base = 13'd2;
        k    = e % GF_N;
        while (k > 0) begin
            if (k % 2 == 1) res = gf_mul(res, base);
            base = gf_mul(base, base);
            k    = k / 2;
        end
        return res;
    endfunction

    // binary minimal polynomial of alpha^i (conjugacy classes all have 13 members)
    function automatic logic [GF_M:0] min_poly(input int i);
        logic [GF_M-1:0] c [0:GF_M];
        logic [GF_M-1:0] r;
        logic [GF_M:0]   m;
        int              ex;
        for (int j = 0; j <= GF_M; j++) c[j] = '0;
        c[0] = 13'd1;
        ex   = i % GF_N;
        for (int k = 0; k < GF_M; k++) begin
            r = gf_pow(ex);
            for (int j = GF_M; j >= 1; j--) c[j] = c[j-1] ^ gf_mul(c[j], r);
            c[0] = gf_mul(c[0], r);
            ex   = (ex * 2) % GF_N;
        end
        for (int j = 0; j <= GF_M; j++) m[j] = c[j][0];
        return m;
    endfunction

    function automatic logic [PAR_MAX:0] gen_poly(input int t);
        logic [PAR_MAX:0] g;
        logic [PAR_MAX:0] prod;
        logic [GF_M:0]    m;
        g = '0;
        g[0] = 1'b1;
        for (int i = 1; i < 2 * t; i += 2) begin
            m    = min_poly(i);
            prod = '0;
            for (int j = 0; j <= GF_M; j++)
                if (m[j]) prod = prod ^ (g << j);
            g = prod;
        end
        return g;
    endfunction

    // shift nbits of d (top bit first) into a degree-deg remainder register
    function automatic logic [PAR_MAX-1:0] lfsr_feed(input logic [PAR_MAX-1:0] st_in,
                                                    input logic [15:0] d,
                                                    input int nbits,
                                                    input int deg,
                                                    input logic [PAR_MAX:0] g);
        logic [PAR_MAX-1:0] st;
        logic [PAR_MAX-1:0] keep;
        logic               fb;
        st   = st_in;
        keep = {PAR_MAX{1'b1}} >> (PAR_MAX - deg);
        for (int i = 15; i >= 0; i--) begin
            if (i < nbits) begin
                fb = d[i] ^ st[deg-1];
                st = (st << 1) & keep;
                if (fb) st = st ^ (g[PAR_MAX-1:0] & keep);
            end
        end
        return st;
    endfunction

    function automatic logic [PAR_MAX-1:0] justify(input logic [PAR_MAX-1:0] rem,
                                                  input logic t8);
        return t8 ? rem : {rem[51:0], 4'b0000, 48'h0};
    endfunction

    function automatic logic [PAR_MAX-1:0] used_bits(input logic t8);
        return t8 ? {PAR_MAX{1'b1}} : {{56{1'b1}}, 48'h0};
    endfunction

    // constant that turns an erased sector's packed parity into all ones
    function automatic logic [PAR_MAX-1:0] erase_mask(input logic t8);
        logic [PAR_MAX-1:0] st;
        logic [PAR_MAX:0]   g;
        int                 deg;
        deg = t8 ? 8 * GF_M : 4 * GF_M;
        g   = gen_poly(t8 ? 8 : 4);
        st  = '0;
        for (int b = 0; b < SECTOR_BYTES; b++) st = lfsr_feed(st, 16'h00FF, 8, deg, g);
        return used_bits(t8) & ~justify(st, t8);
    endfunction

endpackage

// File: rtl/nbp_seq.sv
module nbp_seq
    import nbp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [31:0]      cfg_i,
    input  logic             ctl_wr_i,
    input  logic [15:0]      ctl_i,
    input  logic             data_vld_i,
    output logic             clr_o,
    output logic             feed_o,
    output logic             cap_o,
    output logic [SEC_W-1:0] sec_o,
    output cfg_t             cfg_o,
    output logic             done_o
);

    cfg_t             cfg_q;
    cfg_t             cfg_in;
    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic [SEC_W-1:0] sec_q;
    logic             start;
    logic             skip_spare;

    always_comb begin
        cfg_in     = cfg_decode(cfg_i);
        clr_o      = ctl_wr_i & ctl_i[0];
        start      = clr_o & ctl_i[8] & cfg_in.ecc_en & cfg_in.bch_en;
        cnt_nx     = cnt_q + (cfg_q.wide ? CNT_W'(2) : CNT_W'(1));
        feed_o     = (phase_q == PH_DATA) & data_vld_i & ~clr_o;
        cap_o      = feed_o & (cnt_nx == CNT_W'(SECTOR_BYTES));
        skip_spare = (cfg_q.wrap == WRAP_SKIP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            sec_q   <= '0;
        end else if (clr_o) begin
            phase_q <= start ? PH_DATA : PH_IDLE;
            cnt_q   <= '0;
            sec_q   <= '0;
            if (start) cfg_q <= cfg_in;
        end else begin
            case (phase_q)
                PH_DATA: begin
                    if (feed_o) begin
                        if (cap_o) begin
                            cnt_q <= '0;
                            if (sec_q == cfg_q.nsec_m1) begin
                                phase_q <= PH_DONE;
                            end else begin
                                sec_q   <= sec_q + 1'b1;
                                phase_q <= skip_spare ? PH_SPARE : PH_DATA;
                            end
                        end else begin
                            cnt_q <= cnt_nx;
                        end
                    end
                end
                PH_SPARE: begin
                    if (data_vld_i) begin
                        if (cnt_nx == CNT_W'(SPARE_SKIP)) begin
                            cnt_q   <= '0;
                            phase_q <= PH_DATA;
                        end else begin
                            cnt_q <= cnt_nx;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sec_o  = sec_q;
    assign cfg_o  = cfg_q;
    assign done_o = (phase_q == PH_DONE);

endmodule

// File: rtl/nbp_lfsr.sv
module nbp_lfsr
    import nbp_pkg::*;
#(
    parameter int T_LO = 4,
    parameter int T_HI = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_i,
    input  logic               feed_i,
    input  logic               cap_i,
    input  logic               wide_i,
    input  logic               t8_i,
    input  logic [15:0]        data_i,
    output logic [PAR_MAX-1:0] rem_nx_o
);

    localparam int NSTR = 2;

    logic [PAR_MAX-1:0] state_q;
    logic [PAR_MAX-1:0] step [NSTR];

    for (genvar m = 0; m < NSTR; m++) begin : g_str
        localparam int               T   = (m == 0) ? T_LO : T_HI;
        localparam int               DEG = T * GF_M;
        localparam logic [PAR_MAX:0] GEN = gen_poly(T);
        always_comb step[m] = lfsr_feed(state_q, data_i, wide_i ? 16 : 8, DEG, GEN);
    end

    assign rem_nx_o = t8_i ? step[1] : step[0];

    always_ff @(posedge clk) begin
        if (rst || clr_i || cap_i) state_q <= '0;
        else if (feed_i)           state_q <= rem_nx_o;
    end

endmodule

// File: rtl/nbp_bank.sv
module nbp_bank
    import nbp_pkg::*;
#(
    parameter int N_SECTORS = MAX_SECTORS
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr_i,
    input  logic                         cap_i,
    input  logic [SEC_W-1:0]             sec_i,
    input  logic [PAR_MAX-1:0]           rem_i,
    input  logic                         t8_i,
    output logic [N_SECTORS*BANK_W-1:0]  bank_o,
    output logic [N_SECTORS*PAR_MAX-1:0] parity_o
);

    localparam logic [PAR_MAX-1:0] MASK4 = erase_mask(1'b0);
    localparam logic [PAR_MAX-1:0] MASK8 = erase_mask(1'b1);

    for (genvar s = 0; s < N_SECTORS; s++) begin : g_sec
        logic [PAR_MAX-1:0] held_q;

        always_ff @(posedge clk) begin
            if (rst || clr_i)                        held_q <= '0;
            else if (cap_i && sec_i == SEC_W'(s))    held_q <= rem_i;
        end

        assign bank_o[s*BANK_W +: BANK_W]     = {{(BANK_W-PAR_MAX){1'b0}}, held_q};
        assign parity_o[s*PAR_MAX +: PAR_MAX] = justify(held_q, t8_i) ^ (t8_i ? MASK8 : MASK4);
    end

endmodule

// File: rtl/nand_bch_parity.sv
module nand_bch_parity
    import nbp_pkg::*;
#(
    parameter int N_SECTORS = MAX_SECTORS
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [31:0]                  cfg_i,
    input  logic                         ctl_wr_i,
    input  logic [15:0]                  ctl_i,
    input  logic [15:0]                  data_i,
    input  logic                         data_vld_i,
    output logic [N_SECTORS*BANK_W-1:0]  bank_o,
    output logic [N_SECTORS*PAR_MAX-1:0] parity_o,
    output logic                         done_o
);

    logic               clr;
    logic               feed;
    logic               cap;
    logic [SEC_W-1:0]   sec;
    cfg_t               cfg_q;
    logic               lat_t8;
    logic [PAR_MAX-1:0] rem_nx;

    nbp_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .cfg_i      (cfg_i),
        .ctl_wr_i   (ctl_wr_i),
        .ctl_i      (ctl_i),
        .data_vld_i (data_vld_i),
        .clr_o      (clr),
        .feed_o     (feed),
        .cap_o      (cap),
        .sec_o      (sec),
        .cfg_o      (cfg_q),
        .done_o     (done_o)
    );

    assign lat_t8 = cfg_q.t8;

    nbp_lfsr u_lfsr (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (clr),
        .feed_i   (feed),
        .cap_i    (cap),
        .wide_i   (cfg_q.wide),
        .t8_i     (lat_t8),
        .data_i   (data_i),
        .rem_nx_o (rem_nx)
    );

    nbp_bank #(.N_SECTORS(N_SECTORS)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (clr),
        .cap_i    (cap),
        .sec_i    (sec),
        .rem_i    (rem_nx),
        .t8_i     (lat_t8),
        .bank_o   (bank_o),
        .parity_o (parity_o)
    );

endmodule

// File: rtl/nbp_checker.sv
module nbp_checker
    import nbp_pkg::*;
#(
    parameter int N_SECTORS = MAX_SECTORS
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        ctl_wr_i,
    input logic [15:0]                 ctl_i,
    input logic                        data_vld_i,
    input logic [N_SECTORS*BANK_W-1:0] bank_o,
    input logic                        done_o,
    input logic                        t8_q
);

    logic clr_w;
    assign clr_w = ctl_wr_i & ctl_i[0];

    p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
        done_o && !clr_w |=> done_o);

    p_frozen_after_done_r6: assert property (@(posedge clk) disable iff (rst)
        done_o && !clr_w |=> $stable(bank_o));

    p_done_on_beat_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(data_vld_i));

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        clr_w |=> (bank_o == '0) && !done_o);

    for (genvar s = 0; s < N_SECTORS; s++) begin : g_chk
        p_upper_words_r4: assert property (@(posedge clk) disable iff (rst)
            !t8_q |-> bank_o[s*BANK_W+52 +: BANK_W-52] == '0);
    end

endmodule

bind nand_bch_parity nbp_checker #(.N_SECTORS(N_SECTORS)) u_nbp_checker (
    .clk        (clk),
    .rst        (rst),
    .ctl_wr_i   (ctl_wr_i),
    .ctl_i      (ctl_i),
    .data_vld_i (data_vld_i),
    .bank_o     (bank_o),
    .done_o     (done_o),
    .t8_q       (lat_t8)
);

// File: tb/test_nand_bch_parity.sv
`timescale 1ns/1ps
module test_nand_bch_parity;

    localparam int NS = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic [31:0]      cfg_i;
    logic             ctl_wr_i;
    logic [15:0]      ctl_i;
    logic [15:0]      data_i;
    logic             data_vld_i;
    logic [NS*128-1:0] bank_o;
    logic [NS*104-1:0] parity_o;
    logic             done_o;

    int errs = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [104:0] g4, g8;
    logic [103:0] m4, m8;

    always #5 clk = ~clk;

    nand_bch_parity #(.N_SECTORS(NS)) i_nand_bch_parity (
        .clk(clk), .rst(rst), .cfg_i(cfg_i), .ctl_wr_i(ctl_wr_i), .ctl_i(ctl_i),
        .data_i(data_i), .data_vld_i(data_vld_i), .bank_o(bank_o),
        .parity_o(parity_o), .done_o(done_o)
    );

    // ---- independent arithmetic model ----
    function automatic logic [12:0] tmul(input logic [12:0] a, input logic [12:0] b);
        logic [12:0] r;
        logic [12:0] x;
        r = '0;
        x = a;
        for (int i = 0; i < 13; i++) begin
            if (b[i]) r ^= x;
            x = x[12] ? ((x << 1) ^ 13'h001B) : (x << 1);
        end
        return r;
    endfunction

    function automatic logic [12:0] tpow(input int e);
        logic [12:0] r;
        r = 13'd1;
        for (int i = 0; i < 13; i++) begin
            r = tmul(r, r);
            if ((e >> (12 - i)) & 1) r = tmul(r, 13'd2);
        end
        return r;
    endfunction

    // product of (x + root) over every conjugate of the odd powers below 2t (R2)
    function automatic logic [104:0] tgen(input int t);
        logic [12:0] c [0:104];
        logic [104:0] g;
        int deg;
        int ex;
        for (int j = 0; j <= 104; j++) c[j] = '0;
        c[0] = 13'd1;
        deg = 0;
        for (int i = 1; i < 2 * t; i += 2) begin
            ex = i;
            for (int k = 0; k < 13; k++) begin
                for (int j = deg + 1; j >= 1; j--) c[j] = c[j-1] ^ tmul(c[j], tpow(ex));
                c[0] = tmul(c[0], tpow(ex));
                deg++;
                ex = (ex * 2) % 8191;
            end
        end
        for (int j = 0; j <= 104; j++) g[j] = c[j][0];
        return g;
    endfunction

    function automatic logic [7:0] byte_at(input int pat, input int s, input int i);
        int p;
        int h;
        p = (pat == 3) ? (s % 3) : pat;
        if (p == 0) return 8'hFF;
        if (p == 1) return 8'h00;
        h = i * 1103 + s * 7919 + 12345;
        h = h ^ (h >> 7);
        h = h * 5 + (h >> 3);
        return h[7:0];
    endfunction

    // long division of the sector message times x^N, one bit at a time (R1, R2)
    function automatic logic [103:0] ref_rem(input bit t8, input int pat, input int s);
        logic [105:0] r;
        logic [104:0] g;
        logic [7:0]   bt;
        int n;
        logic b;
        n = t8 ? 104 : 52;
        g = t8 ? g8 : g4;
        r = '0;
        for (int i = 0; i < 4096 + n; i++) begin
            if (i < 4096) begin
                bt = byte_at(pat, s, i / 8);
                b  = bt[7 - (i % 8)];
            end else begin
                b = 1'b0;
            end
            r = (r << 1) | 106'(b);
            if (r[n]) r = r ^ 106'(g);
        end
        return r[103:0];
    endfunction

    function automatic logic [103:0] tpack(input logic [103:0] rem, input bit t8);
        if (t8) return rem;
        return {rem[51:0], 52'h0};
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [31:0] c, input logic [15:0] w);
        @(negedge clk);
        cfg_i    = c;
        ctl_wr_i = 1'b1;
        ctl_i    = w;
        @(negedge clk);
        ctl_wr_i = 1'b0;
        ctl_i    = '0;
    endtask

    task automatic beat(input logic [15:0] d);
        @(negedge clk);
        data_vld_i = 1'b1;
        data_i     = d;
    endtask

    task automatic idle_beat();
        @(negedge clk);
        data_vld_i = 1'b0;
    endtask

    task automatic verify_banks(input bit t8, input int nsec, input int pat, input string tag);
        logic [103:0] e;
        logic [103:0] exp_par;
        for (int s = 0; s < NS; s++) begin
            if (s < nsec) begin
                e = ref_rem(t8, pat, s);
                exp_par = tpack(e, t8) ^ (t8 ? m8 : m4);
                check(bank_o[s*128 +: 128] == {24'h0, e}, {tag, " R1 R2 R4 bank"},
                      bank_o[s*128 +: 128], {24'h0, e});
                check(parity_o[s*104 +: 104] == exp_par, {tag, " R8 packed"},
                      128'(parity_o[s*104 +: 104]), 128'(exp_par));
            end else begin
                check(bank_o[s*128 +: 128] == '0, {tag, " R4 unused bank"},
                      bank_o[s*128 +: 128], '0);
            end
        end
    endtask

    task automatic run(input bit t8, input bit wide, input int nsec, input int pat,
                       input bit skip, input bit cfg_flip, input string tag);
        logic [31:0] c;
        int bpb;
        c = {15'h0, 1'b1, 3'b000, t8, (skip ? 4'd6 : 4'd0), wide, 3'(nsec - 1), 3'd5, 1'b1};
        bpb = wide ? 2 : 1;
        ctl_write(c, 16'h0101);
        for (int s = 0; s < nsec; s++) begin
            for (int b = 0; b < 512 / bpb; b++) begin
                if (s == nsec - 1 && b == 512 / bpb - 1)
                    check(done_o == 1'b0, {tag, " R6 done before last beat"}, 128'(done_o), 0);
                if (cfg_flip && s == 0 && b == 100) cfg_i = 32'h0;
                if (wide) beat({byte_at(pat, s, 2 * b), byte_at(pat, s, 2 * b + 1)});
                else      beat({8'h5A, byte_at(pat, s, b)});
            end
            if (skip && s < nsec - 1)
                for (int k = 0; k < 16 / bpb; k++) beat(16'hA5A5);
        end
        idle_beat();
        check(done_o == 1'b1, {tag, " R6 done after last beat"}, 128'(done_o), 1);
        verify_banks(t8, nsec, pat, tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_i = '0; ctl_wr_i = 1'b0; ctl_i = '0; data_i = '0; data_vld_i = 1'b0;
        g4 = tgen(4);
        g8 = tgen(8);
        m4 = {{56{1'b1}}, 48'h0} & ~tpack(ref_rem(1'b0, 0, 0), 1'b0);
        m8 = ~tpack(ref_rem(1'b1, 0, 0), 1'b1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(done_o == 1'b0, "R9 done at reset", 128'(done_o), 0);
        check(bank_o == '0, "R9 banks at reset", bank_o[127:0], 0);

        // erased sectors give all-ones packed parity (R8)
        run(1'b0, 1'b0, 1, 0, 1'b1, 1'b0, "t4 erased");
        check(parity_o[103:0] == {{56{1'b1}}, 48'h0}, "R8 t4 erased all ones",
              128'(parity_o[103:0]), 128'({{56{1'b1}}, 48'h0}));
        run(1'b1, 1'b0, 1, 0, 1'b1, 1'b0, "t8 erased");
        check(parity_o[103:0] == {104{1'b1}}, "R8 t8 erased all ones",
              128'(parity_o[103:0]), 128'({104{1'b1}}));

        // zero sector and data after done (R6)
        run(1'b1, 1'b0, 1, 1, 1'b1, 1'b0, "t8 zero");
        run(1'b0, 1'b1, 2, 2, 1'b1, 1'b0, "t4 x16 R3");
        for (int k = 0; k < 40; k++) beat(16'(k * 977));
        idle_beat();
        check(done_o == 1'b1, "R6 done holds", 128'(done_o), 1);
        verify_banks(1'b0, 2, 2, "R6 ignore after done");

        // sweep sector counts, strengths, widths, spare handling (R4 R5 R3)
        for (int n = 1; n <= 8; n++)
            run(1'(n % 2), (n >= 5), n, 3, (n != 3 && n != 6), 1'b0, "sweep R4 R5");
        run(1'b1, 1'b1, 2, 2, 1'b0, 1'b0, "t8 x16 no skip R5");

        // configuration change mid-run (R10)
        run(1'b1, 1'b0, 1, 2, 1'b1, 1'b1, "R10 cfg latched");

        // clear only (R7)
        ctl_write(32'h0001_1001, 16'h0001);
        check(bank_o == '0, "R7 clear banks", bank_o[127:0], 0);
        check(done_o == 1'b0, "R7 clear done", 128'(done_o), 0);
        for (int k = 0; k < 30; k++) beat(16'h1234);
        idle_beat();
        check(bank_o == '0, "R7 idle ignores data", bank_o[127:0], 0);
        // start with BCH disabled (R7)
        ctl_write(32'h0000_1001, 16'h0101);
        for (int k = 0; k < 520; k++) beat(16'(k));
        idle_beat();
        check(bank_o == '0, "R7 no start without bch", bank_o[127:0], 0);
        check(done_o == 1'b0, "R7 no done without bch", 128'(done_o), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule